// File: doc/BRIEF.md
# 8-bit Prescaled Timer with Latched Interrupt Request

An 8-bit up-counter advances once per tick of a selectable clock divider. When it rolls over from 0xFF to 0x00 it latches a pending-request flag. The flag is set whether or not the timer interrupt is enabled. The block does not reload itself. After a rollover the count simply carries on from 0x00. Software sets up the next interval by rewriting the count, normally from the service routine, where it also clears the flag.

Software sees the block through a small write port. Four word addresses select the divider mode, the count, a control word holding the run, interrupt-enable and global-enable bits, and the flag. The interrupt request output is a level. It asks the core to jump to a fixed vector and stays high until software clears the flag. A request that was latched while masked fires as soon as both enables are set.

Top module: `tmr8_irq`

## Requirements
- R1: After reset, cnt_o is 0x00, flag_o and irq_o are 0, the timer is stopped and both enables are 0.
- R2: Mode address 0 sets the divider through bits [6:4] = code n. The count then advances once every 256 >> n clock cycles. Code 2 (mode value 0x20) divides by 64.
- R3: The count rolls over from 0xFF to 0x00 and latches flag_o. It then carries on from 0x00 with no reload.
- R4: A rollover latches flag_o even when the timer interrupt enable (control bit 1) is 0.
- R5: irq_o is high exactly when flag_o, the timer interrupt enable (control bit 1) and the global enable (control bit 2) are all 1. A flag latched earlier raises irq_o once both enables are set.
- R6: With the run bit (control bit 0, address 2) at 0, the count holds its value.
- R7: The flag changes only through a rollover or a write to address 3, which stores data bit 0. Writes to the other addresses leave it unchanged.
- R8: If a write of 0 to the flag and a rollover fall on the same clock edge, the flag ends up set.
- R9: A write to address 1 loads the count and restarts the divider phase. The first increment after the load comes exactly one full divide period after the write edge.
- R10: vector_o carries the fixed interrupt vector 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write address: 0 mode, 1 count, 2 control, 3 flag |
| wr_data_i | input | 8 | Write data |
| cnt_o | output | 8 | Current count |
| flag_o | output | 1 | Pending request flag |
| irq_o | output | 1 | Interrupt request level |
| vector_o | output | 8 | Fixed interrupt vector |

## Verification
All writes are registered on the edge that samples them, so a loaded count is visible one edge after the write. The first increment comes exactly D edges after the load edge, where D is the selected divide. The rollover, and the flag it latches, come D edges after the count reaches 0xFF. irq_o follows the flag and enables with no extra delay. The bench drives writes on falling edges and counts falling edges from the load. It samples the count at D-1 and D to pin the first increment to its cycle, then at 2D and 3D for the rollover and the restart from 0x00. The same-edge clear test places the flag write on the rollover edge of a divide-by-2 setting.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ADDR_MODE = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_FLAG = 2'd3
  } tmr_addr_e;

  typedef struct packed {
    logic gie;
    logic ien;
    logic run;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned MAX_DIV = 1 << PRE_W;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   div_w;
  logic [PRE_W-1:0] term_w;

  assign div_w  = (PRE_W+1)'(MAX_DIV) >> sel_i;
  assign term_w = PRE_W'(div_w - 1'b1);
  assign tick_o = run_i && !restart_i && (pre_q == term_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (run_i)     pre_q <= tick_o ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  // a load on the same edge takes priority and suppresses the rollover
  assign ovf_o = tick_i && !load_i && (cnt_q == {CNT_W{1'b1}});
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wr_i,
  input  logic wr_val_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;   // rollover beats a same-edge clear
    else if (wr_i)  flag_o <= wr_val_i;
  end
endmodule

// File: rtl/tmr8_irq.sv
module tmr8_irq
  import tmr_pkg::*;
#(
  parameter int          CNT_W   = 8,
  parameter int          SEL_W   = 3,
  parameter int          SEL_LSB = 4,
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  VECTOR  = 8'd8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic [7:0]        vector_o
);
  localparam int CTRL_W = $bits(tmr_ctrl_t);

  logic [SEL_W-1:0] mode_q;
  tmr_ctrl_t        ctrl_q;
  logic             wr_mode, wr_cnt, wr_ctrl, wr_flag;
  logic             tick, ovf;

  assign wr_mode = wr_en_i && (tmr_addr_e'(wr_addr_i) == ADDR_MODE);
  assign wr_cnt  = wr_en_i && (tmr_addr_e'(wr_addr_i) == ADDR_CNT);
  assign wr_ctrl = wr_en_i && (tmr_addr_e'(wr_addr_i) == ADDR_CTRL);
  assign wr_flag = wr_en_i && (tmr_addr_e'(wr_addr_i) == ADDR_FLAG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_mode) mode_q <= wr_data_i[SEL_LSB +: SEL_W];
      if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(wr_data_i[CTRL_W-1:0]);
    end
  end

  tmr_prescaler #(.PRE_W(CNT_W), .SEL_W(SEL_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (ctrl_q.run),
    .restart_i (wr_cnt),
    .sel_i     (mode_q),
    .tick_o    (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_cnt),
    .load_val_i (wr_data_i[CNT_W-1:0]),
    .tick_i     (tick),
    .cnt_o      (cnt_o),
    .ovf_o      (ovf)
  );

  tmr_irq_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (ovf),
    .wr_i     (wr_flag),
    .wr_val_i (wr_data_i[0]),
    .flag_o   (flag_o)
  );

  assign irq_o    = flag_o && ctrl_q.ien && ctrl_q.gie;
  assign vector_o = VECTOR;
endmodule

// File: rtl/tmr8_irq_chk.sv
module tmr8_irq_chk #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              flag_o,
  input logic              irq_o,
  input logic              run
);
  logic wr_cnt, wr_flag;
  assign wr_cnt  = wr_en_i && (wr_addr_i == 2'd1);
  assign wr_flag = wr_en_i && (wr_addr_i == 2'd3);

  assert_irq_needs_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);

  assert_wrap_sets_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0 && $past(cnt_o) == {CNT_W{1'b1}} && !$past(wr_cnt)) |-> flag_o);

  assert_flag_clear_by_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> ($past(wr_flag) && !$past(wr_data_i[0])));

  assert_stopped_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(run) && !$past(wr_cnt)) |-> $stable(cnt_o));
endmodule

bind tmr8_irq tmr8_irq_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .cnt_o     (cnt_o),
  .flag_o    (flag_o),
  .irq_o     (irq_o),
  .run       (ctrl_q.run)
);

// File: tb/tb_tmr8_irq.sv
`timescale 1ns/1ps
module tb_tmr8_irq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] cnt_o;
  logic       flag_o, irq_o;
  logic [7:0] vector_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk_i = ~clk_i;

  tmr8_irq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .cnt_o(cnt_o), .flag_o(flag_o), .irq_o(irq_o),
    .vector_o(vector_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(5ns * 150000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset state
    chk(cnt_o == 8'h00, "R1 cnt", cnt_o, 0);
    chk(flag_o == 1'b0, "R1 flag", flag_o, 0);
    chk(irq_o == 1'b0, "R1 irq", irq_o, 0);
    chk(vector_o == 8'd8, "R10 vector", vector_o, 8);
    idle(20);
    chk(cnt_o == 8'h00, "R1 R6 stopped after reset", cnt_o, 0);

    // sweep of all divider codes, enables varied per code
    for (int code = 0; code < 8; code++) begin
      automatic int div = 256 >> code;
      automatic bit ien = code[0];
      automatic bit gie = code[1];
      wr(2'd0, 8'(code << 4));
      wr(2'd2, {5'b0, gie, ien, 1'b1});
      wr(2'd3, 8'h00);
      wr(2'd1, 8'hFE);
      idle(div - 1);
      chk(cnt_o == 8'hFE, "R9 no early step", cnt_o, 8'hFE);
      idle(1);
      chk(cnt_o == 8'hFF, "R2 R9 step after one period", cnt_o, 8'hFF);
      chk(irq_o == 1'b0, "R5 no irq before wrap", irq_o, 0);
      idle(div);
      chk(cnt_o == 8'h00, "R3 wrap", cnt_o, 0);
      chk(flag_o == 1'b1, "R3 R4 flag on wrap", flag_o, 1);
      chk(irq_o == (ien & gie), "R5 irq gating", irq_o, ien & gie);
      idle(div);
      chk(cnt_o == 8'h01, "R3 continues without reload", cnt_o, 1);
    end

    // R6: stop holds count, restart resumes
    wr(2'd0, 8'h70);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h40);
    idle(300);
    chk(cnt_o == 8'h40, "R6 stopped holds", cnt_o, 8'h40);

    // R4 R5: masked wrap, then stale request fires when unmasked
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h03);          // run, ien, gie=0
    wr(2'd1, 8'hFF);
    idle(2);
    chk(flag_o == 1'b1, "R4 flag while gie off", flag_o, 1);
    chk(irq_o == 1'b0, "R5 masked by gie", irq_o, 0);
    wr(2'd2, 8'h06);          // stop, ien, gie
    chk(irq_o == 1'b1, "R5 stale request fires", irq_o, 1);

    // R7: other writes leave flag alone; flag write of 0 clears
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h10);
    wr(2'd2, 8'h06);
    chk(flag_o == 1'b1, "R7 flag kept across other writes", flag_o, 1);
    wr(2'd3, 8'hFE);
    chk(flag_o == 1'b0, "R7 flag cleared", flag_o, 0);
    chk(irq_o == 1'b0, "R5 irq drops with flag", irq_o, 0);
    wr(2'd3, 8'h01);
    chk(flag_o == 1'b1, "R7 flag stores bit 0", flag_o, 1);
    wr(2'd3, 8'h00);

    // R8: clear on the rollover edge loses
    wr(2'd0, 8'h70);
    wr(2'd2, 8'h01);
    wr(2'd1, 8'hFF);
    idle(1);
    wr(2'd3, 8'h00);          // sampled on the rollover edge
    chk(cnt_o == 8'h00, "R8 wrap occurred", cnt_o, 0);
    chk(flag_o == 1'b1, "R8 rollover beats clear", flag_o, 1);

    // R2: mode value 0x20 divides by 64
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h05);
    idle(64 * 3);
    chk(cnt_o == 8'h08, "R2 divide by 64", cnt_o, 8'h08);

    summary();
  end
endmodule